// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by walking a four-level tree of 64-bit translation entries in memory. A caller hands it the virtual address, the root table pointer and a flag saying whether the no-execute bit is in use. The walker then issues one 64-bit read per level on a valid/ready memory port. It checks each entry for presence and for reserved bits. At the last level, or at an earlier large-page leaf, it returns the physical address, the page size and the merged user, write and no-execute attributes. If the walk fails, it returns a fault cause instead.

Each table entry that the walk passes through on the way down is marked as accessed. The walker does this with an atomic compare-and-write of the entry's low 32 bits on the same memory port. If another agent changed the entry in the meantime, the compare fails and the walker reads that level again. A walk can stop at the second level with a 1 GB page or at the third level with a 2 MB page.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and whenever no walk is running, `req_ready` is high and no memory request is issued. A request whose virtual address bits 63:47 are not all equal ends the next cycle with `res_cause` = 3 (non-canonical) and makes no memory access.
- R2: Each read goes to table base + (index << 3). The base for the first read is the root pointer with bits below 12 cleared, limited to the physical width. For later reads it is the physical frame of the entry just read. The index comes from virtual bits 47:39, then 38:30, then 29:21, then 20:12.
- R3: An entry with bit 0 (present) clear ends the walk with `res_cause` = 1.
- R4: An entry gives `res_cause` = 2 (reserved) if any of its bits 51 down to the configured physical width is set. It also gives that fault if bit 63 is set while no-execute is disabled.
- R5: Bit 7 (page size) set in a top-level entry is a reserved-bit fault. In a last-level entry, bit 7 has no effect on the walk.
- R6: Bit 7 set at the second level ends the walk with a 1 GB page (`res_size` = 2). At the third level it ends the walk with a 2 MB page (`res_size` = 1). Such a leaf faults with cause 2 if any bit from 13 up to the page-size bit position minus one is set. Bit 12 is allowed.
- R7: A non-leaf entry with bit 5 (accessed) clear is followed by a write request to the same address, before the next level is read. The write's compare value is the entry's low 32 bits, and its write data is the same value with bit 5 set. Leaf entries, and entries whose bit 5 is already set, cause no write.
- R8: When the memory reports that the compare did not match, the walker reads the same entry address again and continues from the new value.
- R9: The result's user (bit 2) and write (bit 1) attributes are the AND of those bits over every entry the walk reads. The no-execute attribute (bit 63) is their OR.
- R10: On success, `res_paddr` is the leaf's frame with the bits below the page size cleared, ORed with the virtual address bits below the page size. `res_cause` is 0, and `res_size` is 0 for a 4 KB page.
- R11: A memory request that is not accepted stays valid, with the same address and direction, until `mem_req_ready` is high.
- R12: Each walk produces exactly one single-cycle `res_valid` pulse. A faulting result carries a physical address of 0, size 0 and all attributes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root table pointer |
| req_nx_en | input | 1 | No-execute bit enabled in entries |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = compare-and-write, 0 = 64-bit read |
| mem_req_addr | output | PA_BITS | Entry byte address |
| mem_req_cmp | output | 32 | Expected low word for compare-and-write |
| mem_req_wdata | output | 32 | New low word for compare-and-write |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 64 | Read data |
| mem_rsp_match | input | 1 | Compare-and-write succeeded |
| res_valid | output | 1 | Result pulse |
| res_cause | output | 2 | 0 ok, 1 not present, 2 reserved, 3 non-canonical |
| res_paddr | output | PA_BITS | Translated physical address |
| res_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| res_user | output | 1 | Merged user attribute |
| res_write | output | 1 | Merged write attribute |
| res_noexec | output | 1 | Merged no-execute attribute |

## Verification
The bench targets a failed compare-and-write. A walker that descended anyway, or that retried the write with stale data, would show a different number of reads and writes than the expected count. It checks large leaves whose low address bits are set, where only bit 12 is legal. A walker with the wrong window would either accept a corrupt leaf or reject a valid one. It also checks a size bit at the top level and at the last level, and entries that already have the accessed bit set; a walker that wrote them anyway would show up in the write count. Finally, it checks addresses that fail the canonical test, where any memory traffic at all means the early reject is missing, and stalls on the request handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_BITS    = 48;
    localparam int LEVELS     = 4;
    localparam int IDX_BITS   = 9;
    localparam int PAGE_SHIFT = 12;
    localparam int ENT_SHIFT  = 3;
    localparam int ADDR_TOP   = 51;
    localparam int VPN_BITS   = VA_BITS - PAGE_SHIFT;

    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITE    = 1;
    localparam int BIT_USER     = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_LARGE    = 7;
    localparam int BIT_NOEXEC   = 63;

    localparam logic [1:0] LVL_TOP = 2'd3;
    localparam logic [1:0] LVL_1G  = 2'd2;
    localparam logic [1:0] LVL_2M  = 2'd1;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NOT_PRESENT = 2'd1,
        FLT_RESERVED    = 2'd2,
        FLT_NONCANON    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pgsize_e;

    typedef struct packed {
        logic user;
        logic write;
        logic noexec;
    } attr_t;

    localparam attr_t ATTR_INIT = '{user: 1'b1, write: 1'b1, noexec: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_EVAL,
        ST_CAS_REQ,
        ST_CAS_WAIT,
        ST_DONE
    } state_e;

    function automatic int size_shift(pgsize_e sz);
        case (sz)
            PG_1G:   return PAGE_SHIFT + 2 * IDX_BITS;
            PG_2M:   return PAGE_SHIFT + IDX_BITS;
            default: return PAGE_SHIFT;
        endcase
    endfunction

    function automatic logic [63:0] rsvd_addr_mask(int pa_bits);
        logic [63:0] m;
        m = '0;
        for (int b = PAGE_SHIFT; b <= ADDR_TOP; b++) begin
            m[b] = (b >= pa_bits);
        end
        return m;
    endfunction

    function automatic logic [63:0] large_low_mask(pgsize_e sz);
        logic [63:0] m;
        int          top;
        m   = '0;
        top = size_shift(sz);
        for (int b = PAGE_SHIFT + 1; b < 64; b++) begin
            m[b] = (b < top);
        end
        return m;
    endfunction

    function automatic logic [63:0] offset_mask(pgsize_e sz);
        return (64'h1 << size_shift(sz)) - 64'h1;
    endfunction

endpackage

// File: rtl/ptw_index_addr.sv
module ptw_index_addr
    import ptw_pkg::*;
#(
    parameter int PA_BITS = 40
) (
    input  logic [VPN_BITS-1:0]           vpn,
    input  logic [1:0]                    level,
    input  logic [PA_BITS-PAGE_SHIFT-1:0] base_frame,
    output logic [PA_BITS-1:0]            ent_addr
);
    logic [IDX_BITS-1:0] idx [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = vpn[g*IDX_BITS +: IDX_BITS];
    end

    // base is page aligned, so the add is a concatenation
    assign ent_addr = {base_frame, idx[level], {ENT_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int PA_BITS = 40
) (
    input  logic [63:0] entry,
    input  logic [1:0]  level,
    input  logic        nx_en,
    output fault_e      fault,
    output logic        is_leaf,
    output pgsize_e     size
);
    localparam logic [63:0] ADDR_RSVD = rsvd_addr_mask(PA_BITS);
    localparam logic [63:0] NX_BIT    = 64'h1 << BIT_NOEXEC;

    logic [63:0] rsvd_mask;
    logic        top_large;
    logic        low_bad;
    logic        rsvd_hit;

    assign rsvd_mask = ADDR_RSVD | (nx_en ? 64'h0 : NX_BIT);

    always_comb begin
        is_leaf   = 1'b0;
        size      = PG_4K;
        top_large = 1'b0;
        unique case (level)
            LVL_TOP: top_large = entry[BIT_LARGE];
            LVL_1G: begin
                is_leaf = entry[BIT_LARGE];
                size    = PG_1G;
            end
            LVL_2M: begin
                is_leaf = entry[BIT_LARGE];
                size    = PG_2M;
            end
            default: begin
                is_leaf = 1'b1;
                size    = PG_4K;
            end
        endcase
    end

    assign low_bad  = is_leaf && (size != PG_4K) && |(entry & large_low_mask(size));
    assign rsvd_hit = |(entry & rsvd_mask) || top_large || low_bad;

    always_comb begin
        if (!entry[BIT_PRESENT]) begin
            fault = FLT_NOT_PRESENT;
        end else if (rsvd_hit) begin
            fault = FLT_RESERVED;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/ptw_leaf_compose.sv
module ptw_leaf_compose
    import ptw_pkg::*;
#(
    parameter int PA_BITS = 40
) (
    input  logic [63:0]         entry,
    input  logic [VA_BITS-1:0]  vaddr,
    input  pgsize_e             size,
    output logic [PA_BITS-1:0]  paddr
);
    localparam logic [63:0] PA_MASK   = (64'h1 << PA_BITS) - 64'h1;
    localparam logic [63:0] PAGE_MASK = (64'h1 << PAGE_SHIFT) - 64'h1;

    logic [63:0] off_m;
    logic [63:0] frame;
    logic [63:0] full;

    assign off_m = offset_mask(size);
    assign frame = entry & PA_MASK & ~PAGE_MASK;
    assign full  = (frame & ~off_m) | ({{(64-VA_BITS){1'b0}}, vaddr} & off_m);
    assign paddr = full[PA_BITS-1:0];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_BITS = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [63:0]        req_vaddr,
    input  logic [63:0]        req_root,
    input  logic               req_nx_en,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [PA_BITS-1:0] mem_req_addr,
    output logic [31:0]        mem_req_cmp,
    output logic [31:0]        mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [63:0]        mem_rsp_rdata,
    input  logic               mem_rsp_match,
    output logic               res_valid,
    output logic [1:0]         res_cause,
    output logic [PA_BITS-1:0] res_paddr,
    output logic [1:0]         res_size,
    output logic               res_user,
    output logic               res_write,
    output logic               res_noexec
);
    localparam int FRAME_W = PA_BITS - PAGE_SHIFT;

    state_e               state_q;
    logic [1:0]           level_q;
    logic [63:0]          entry_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [VA_BITS-1:0]   vaddr_q;
    logic                 nxen_q;
    attr_t                attr_q;
    fault_e               res_cause_q;
    logic [PA_BITS-1:0]   res_paddr_q;
    pgsize_e              res_size_q;
    attr_t                res_attr_q;

    logic                 canon;
    logic [PA_BITS-1:0]   ent_addr;
    fault_e               ev_fault;
    logic                 ev_leaf;
    pgsize_e              ev_size;
    logic [PA_BITS-1:0]   leaf_paddr;
    attr_t                attr_next;
    logic                 unused_root;

    assign unused_root = ^{req_root[63:PA_BITS], req_root[PAGE_SHIFT-1:0]};
    assign canon = (&req_vaddr[63:VA_BITS-1]) || !(|req_vaddr[63:VA_BITS-1]);

    ptw_index_addr #(.PA_BITS(PA_BITS)) u_index (
        .vpn        (vaddr_q[VA_BITS-1:PAGE_SHIFT]),
        .level      (level_q),
        .base_frame (frame_q),
        .ent_addr   (ent_addr)
    );

    ptw_entry_eval #(.PA_BITS(PA_BITS)) u_eval (
        .entry   (entry_q),
        .level   (level_q),
        .nx_en   (nxen_q),
        .fault   (ev_fault),
        .is_leaf (ev_leaf),
        .size    (ev_size)
    );

    ptw_leaf_compose #(.PA_BITS(PA_BITS)) u_compose (
        .entry (entry_q),
        .vaddr (vaddr_q),
        .size  (ev_size),
        .paddr (leaf_paddr)
    );

    always_comb begin
        attr_next.user   = attr_q.user  & entry_q[BIT_USER];
        attr_next.write  = attr_q.write & entry_q[BIT_WRITE];
        attr_next.noexec = attr_q.noexec | entry_q[BIT_NOEXEC];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            level_q     <= '0;
            entry_q     <= '0;
            frame_q     <= '0;
            vaddr_q     <= '0;
            nxen_q      <= 1'b0;
            attr_q      <= ATTR_INIT;
            res_cause_q <= FLT_NONE;
            res_paddr_q <= '0;
            res_size_q  <= PG_4K;
            res_attr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr[VA_BITS-1:0];
                        nxen_q  <= req_nx_en;
                        frame_q <= req_root[PA_BITS-1:PAGE_SHIFT];
                        level_q <= LVL_TOP;
                        attr_q  <= ATTR_INIT;
                        if (!canon) begin
                            res_cause_q <= FLT_NONCANON;
                            res_paddr_q <= '0;
                            res_size_q  <= PG_4K;
                            res_attr_q  <= '0;
                            state_q     <= ST_DONE;
                        end else begin
                            state_q <= ST_RD_REQ;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready) state_q <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        entry_q <= mem_rsp_rdata;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (ev_fault != FLT_NONE) begin
                        res_cause_q <= ev_fault;
                        res_paddr_q <= '0;
                        res_size_q  <= PG_4K;
                        res_attr_q  <= '0;
                        state_q     <= ST_DONE;
                    end else if (ev_leaf) begin
                        res_cause_q <= FLT_NONE;
                        res_paddr_q <= leaf_paddr;
                        res_size_q  <= ev_size;
                        res_attr_q  <= attr_next;
                        state_q     <= ST_DONE;
                    end else if (entry_q[BIT_ACCESSED]) begin
                        frame_q <= entry_q[PA_BITS-1:PAGE_SHIFT];
                        level_q <= level_q - 2'd1;
                        attr_q  <= attr_next;
                        state_q <= ST_RD_REQ;
                    end else begin
                        state_q <= ST_CAS_REQ;
                    end
                end
                ST_CAS_REQ: begin
                    if (mem_req_ready) state_q <= ST_CAS_WAIT;
                end
                ST_CAS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_match) begin
                            frame_q <= entry_q[PA_BITS-1:PAGE_SHIFT];
                            level_q <= level_q - 2'd1;
                            attr_q  <= attr_next;
                        end
                        state_q <= ST_RD_REQ;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_CAS_REQ);
    assign mem_req_write = (state_q == ST_CAS_REQ);
    assign mem_req_addr  = ent_addr;
    assign mem_req_cmp   = entry_q[31:0];
    assign mem_req_wdata = entry_q[31:0] | (32'h1 << BIT_ACCESSED);

    assign res_valid  = (state_q == ST_DONE);
    assign res_cause  = res_cause_q;
    assign res_paddr  = res_paddr_q;
    assign res_size   = res_size_q;
    assign res_user   = res_attr_q.user;
    assign res_write  = res_attr_q.write;
    assign res_noexec = res_attr_q.noexec;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_BITS = 40
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [63:0]        req_vaddr,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [PA_BITS-1:0] mem_req_addr,
    input logic [31:0]        mem_req_cmp,
    input logic [31:0]        mem_req_wdata,
    input logic               res_valid,
    input logic [1:0]         res_cause,
    input logic [PA_BITS-1:0] res_paddr
);
    logic noncanon;
    assign noncanon = !((&req_vaddr[63:47]) || !(|req_vaddr[63:47]));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    p_res_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    p_fault_zero_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_cause != 2'd0 |-> res_paddr == '0);

    p_noncanon_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && noncanon |=> res_valid && res_cause == 2'd3);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    p_cas_value_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> !mem_req_cmp[5] && mem_req_wdata == (mem_req_cmp | 32'h20));

    p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_BITS(PA_BITS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_cmp   (mem_req_cmp),
    .mem_req_wdata (mem_req_wdata),
    .res_valid     (res_valid),
    .res_cause     (res_cause),
    .res_paddr     (res_paddr)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PA = 40;
    localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, PS = 64'h80;
    localparam logic [63:0] PWU = P | W | U;
    localparam logic [63:0] NXB = 64'h1 << 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0, req_ready, req_nx_en = 1'b0;
    logic [63:0]   req_vaddr = '0, req_root = '0;
    logic          mem_req_valid, mem_req_ready, mem_req_write;
    logic [PA-1:0] mem_req_addr;
    logic [31:0]   mem_req_cmp, mem_req_wdata;
    logic          mem_rsp_valid, mem_rsp_match;
    logic [63:0]   mem_rsp_rdata;
    logic          res_valid, res_user, res_write, res_noexec;
    logic [1:0]    res_cause, res_size;
    logic [PA-1:0] res_paddr;

    ptw_walker #(.PA_BITS(PA)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_root(req_root), .req_nx_en(req_nx_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_cmp(mem_req_cmp), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_match(mem_rsp_match),
        .res_valid(res_valid), .res_cause(res_cause), .res_paddr(res_paddr),
        .res_size(res_size), .res_user(res_user), .res_write(res_write),
        .res_noexec(res_noexec)
    );

    logic [63:0] mem [longint];
    int  n_checks = 0, n_fail = 0;
    int  n_rd = 0, n_wr = 0;
    bit  inject_fail = 0;
    bit  expect_res = 0;
    bit  got = 0;
    logic [1:0]    g_cause, g_sz;
    logic [PA-1:0] g_pa;
    logic [2:0]    g_attr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input longint a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic longint slot(input logic [63:0] base, input logic [63:0] va, input int lv);
        return longint'(base + (((va >> (12 + 9*(lv-1))) & 64'h1ff) << 3));
    endfunction

    task automatic build(input logic [63:0] va, input logic [63:0] e4, input logic [63:0] e3,
                         input logic [63:0] e2, input logic [63:0] e1);
        mem[slot(64'h1000, va, 4)] = e4;
        mem[slot(64'h2000, va, 3)] = e3;
        mem[slot(64'h3000, va, 2)] = e2;
        mem[slot(64'h4000, va, 1)] = e1;
    endtask

    // behavioural reference walk over the bench memory
    task automatic model(input logic [63:0] va, input logic [63:0] root, input bit nxe,
                         output logic [1:0] cause, output logic [63:0] pa,
                         output logic [1:0] sz, output logic [2:0] attr);
        logic [63:0] base, e, rmask, pmask;
        bit u, w, nx, done;
        u = 1; w = 1; nx = 0; done = 0;
        cause = 0; pa = 0; sz = 0; attr = 0;
        pmask = (64'h1 << PA) - 1;
        if (va[63:47] != {17{va[47]}}) begin
            cause = 3;
            done = 1;
        end
        rmask = 0;
        for (int b = PA; b < 52; b++) rmask[b] = 1'b1;
        if (!nxe) rmask[63] = 1'b1;
        base = root & pmask & ~64'hfff;
        for (int lv = 4; lv >= 1; lv--) begin
            if (!done) begin
                int shift;
                e = rd(slot(base, va, lv));
                shift = 12 + 9*(lv-1);
                if (!e[0]) begin
                    cause = 1; done = 1;
                end else if ((e & rmask) != 0 || (lv == 4 && e[7])) begin
                    cause = 2; done = 1;
                end else if (lv == 1 || (lv <= 3 && e[7])) begin
                    if (lv > 1 && ((e >> 13) & ((64'h1 << (shift-13)) - 1)) != 0) begin
                        cause = 2;
                    end else begin
                        u = u & e[2]; w = w & e[1]; nx = nx | e[63];
                        pa = (((e & pmask) >> shift) << shift) | (va & ((64'h1 << shift) - 1));
                        sz = 2'(lv - 1);
                        attr = {u, w, nx};
                    end
                    done = 1;
                end else begin
                    u = u & e[2]; w = w & e[1]; nx = nx | e[63];
                    base = e & pmask & ~64'hfff;
                end
            end
        end
    endtask

    // memory responder with periodic backpressure
    initial begin : responder
        int cyc;
        bit pend, pmatch, was_stall;
        logic [63:0] pdata, cur;
        logic [PA-1:0] last_addr;
        longint a;
        cyc = 0; pend = 0; pmatch = 0; pdata = 0; was_stall = 0; last_addr = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0; mem_rsp_match = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = pend;
            mem_rsp_rdata = pend ? pdata : 64'h0;
            mem_rsp_match = pend && pmatch;
            pend = 0;
            if (!rst && was_stall && mem_req_valid)
                chk(mem_req_addr == last_addr, "R11", "address held under stall", 64'(mem_req_addr), 64'(last_addr));
            mem_req_ready = (cyc % 3) != 0;
            was_stall = mem_req_valid && !mem_req_ready;
            last_addr = mem_req_addr;
            if (!rst && mem_req_valid && mem_req_ready) begin
                a = longint'(mem_req_addr);
                cur = rd(a);
                if (!mem_req_write) begin
                    n_rd++;
                    pdata = cur;
                    pmatch = 0;
                end else begin
                    n_wr++;
                    if (inject_fail) begin
                        cur[5] = 1'b1;
                        mem[a] = cur;
                        inject_fail = 0;
                    end
                    pmatch = (cur[31:0] == mem_req_cmp);
                    if (pmatch) mem[a] = {cur[63:32], mem_req_wdata};
                    pdata = 0;
                end
                pend = 1;
            end
        end
    end

    // result monitor, every clock
    initial begin : monitor
        bit prev;
        prev = 0;
        forever begin
            @(negedge clk);
            if (!rst && res_valid) begin
                chk(!prev, "R12", "result pulse longer than one cycle", 1, 0);
                chk(expect_res, "R12", "unexpected result pulse", 1, 0);
                got = 1;
                expect_res = 0;
                g_cause = res_cause; g_pa = res_paddr; g_sz = res_size;
                g_attr = {res_user, res_write, res_noexec};
            end
            prev = res_valid;
        end
    end

    task automatic walk(input logic [63:0] va, input logic [63:0] root, input bit nxe,
                        input int exp_rd, input int exp_wr, input string tag);
        logic [1:0] ec, es;
        logic [63:0] ep;
        logic [2:0] ea;
        int rd0, wr0, t;
        model(va, root, nxe, ec, ep, es, ea);
        rd0 = n_rd; wr0 = n_wr; got = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_root = root; req_nx_en = nxe; expect_res = 1;
        @(negedge clk);
        req_valid = 0;
        t = 0;
        while (!got && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk(got, tag, "result arrived", 64'(got), 1);
        chk(g_cause == ec, tag, "fault cause", 64'(g_cause), 64'(ec));
        chk(g_pa == ep[PA-1:0], tag, "physical address", 64'(g_pa), ep);
        chk(g_sz == es, tag, "page size", 64'(g_sz), 64'(es));
        chk(g_attr == ea, tag, "attributes u/w/nx", 64'(g_attr), 64'(ea));
        if (exp_rd >= 0) chk(n_rd - rd0 == exp_rd, tag, "read count", 64'(n_rd - rd0), 64'(exp_rd));
        if (exp_wr >= 0) chk(n_wr - wr0 == exp_wr, tag, "write count", 64'(n_wr - wr0), 64'(exp_wr));
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] va1, va2;
        va1 = 64'h0000_1234_5678_9ABC;
        va2 = 64'hFFFF_8000_0020_3123;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 1);
        chk(mem_req_valid == 1'b0, "R1", "no memory request after reset", 64'(mem_req_valid), 0);
        chk(res_valid == 1'b0, "R12", "no result after reset", 64'(res_valid), 0);

        // full 4K walk, accessed bits clear
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 64'h4000 | PWU, 64'hA_BCDE_F000 | PWU);
        walk(va1, 64'h1000, 0, 4, 3, "R2,R7,R10");
        chk(rd(slot(64'h1000, va1, 4))[5] && rd(slot(64'h2000, va1, 3))[5] && rd(slot(64'h3000, va1, 2))[5],
            "R7", "accessed set on non-leaf entries", 0, 1);
        chk(rd(slot(64'h4000, va1, 1))[5] == 1'b0, "R7", "leaf entry untouched", 1, 0);

        // attributes merged, accessed already set
        mem.delete();
        build(va1, 64'h2000 | PWU | A, 64'h3000 | P | W | A, 64'h4000 | PWU | A, 64'h55_1000 | P | U | A);
        walk(va1, 64'h1000, 0, 4, 0, "R9,R7");

        // 2 MB page
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 64'h40_6020_0000 | PWU | PS, 0);
        walk(va1, 64'h1000, 0, 3, 2, "R6,R10");
        // 2 MB with a low bit set
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 64'h40_6030_0000 | PWU | PS, 0);
        walk(va1, 64'h1000, 0, 3, 2, "R6");

        // 1 GB page with bit 12 set
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h80_4000_1000 | PWU | PS, 0, 0);
        walk(va1, 64'h1000, 0, 2, 1, "R6");
        // 1 GB with bit 13 set
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h80_4000_2000 | PWU | PS, 0, 0);
        walk(va1, 64'h1000, 0, 2, 1, "R6");

        // not present at third level
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 0, 0);
        walk(va1, 64'h1000, 0, 3, 2, "R3");

        // address bit above physical width
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU | (64'h1 << 45), 0, 0);
        walk(va1, 64'h1000, 0, 2, 1, "R4");

        // no-execute bit with feature off, then on
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 64'h4000 | PWU | NXB, 64'h7000 | PWU);
        walk(va1, 64'h1000, 0, 3, 2, "R4");
        walk(va1, 64'h1000, 1, 4, 1, "R9");

        // size bit at top level
        mem.delete();
        build(va1, 64'h2000 | PWU | PS, 0, 0, 0);
        walk(va1, 64'h1000, 0, 1, 0, "R5");
        // size bit at last level has no effect
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 64'h4000 | PWU, 64'h9000 | PWU | PS);
        walk(va1, 64'h1000, 0, 4, 3, "R5");

        // non-canonical addresses
        walk(64'h0000_8000_0000_0000, 64'h1000, 0, 0, 0, "R1");
        walk(64'hFFFF_0000_0000_0000, 64'h1000, 0, 0, 0, "R1");

        // canonical upper half, root with stray bits
        mem.delete();
        build(va2, 64'h2000 | PWU, 64'h3000 | PWU, 64'h4000 | PWU, 64'hF_0000_0000 | PWU);
        walk(va2, 64'h0004_0000_0000_1ABC, 0, 4, 3, "R2");

        // failed compare forces a re-read
        mem.delete();
        build(va1, 64'h2000 | PWU, 64'h3000 | PWU, 64'h4000 | PWU, 64'hA_BCDE_F000 | PWU);
        inject_fail = 1;
        walk(va1, 64'h1000, 0, 5, 3, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule